// File: doc/BRIEF.md
# Pipeline Interlock and Stall Controller

This block sits beside the decode and execute stages of an in-order pipeline and decides when the younger instruction must wait. It keeps its own decode and execute stage registers, each holding a small descriptor: class, two source register indices, a destination index, a cache-hit flag for loads and a trace tag. It compares the instruction in decode against the one in execute. Only a fixed set of one-cycle hazards makes it stall. These are a load that hit the cache feeding the next instruction, a floating-point result feeding the next instruction, and a store followed directly by a load. All other dependencies are assumed to be covered by bypassing.

Instructions enter on a valid/ready stream. Fetch offers a descriptor with `in_valid`, and the block takes it on a clock edge where `in_ready` is also high. While `in_ready` is low, fetch must keep the same descriptor on the inputs. During a stall the decode descriptor is held and a NOP bubble goes into execute. A branch mispredict, reported while the branch is in execute, flushes the younger instruction and overrides any stall. If the corrected fetch path is not yet available, one extra refill cycle follows.

Top module: `pipe_interlock`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `stall`, `bubble`, `flush` and `ex_valid` are 0 and `in_ready` is 1.
- R2: If execute holds a load (class 2'b01) with its hit flag set and a non-zero destination, and the decode instruction names that destination in either source field, then `stall` and `bubble` are 1 and `in_ready` is 0 for exactly one cycle.
- R3: If execute holds a floating-point instruction (class 2'b11) with a non-zero destination that the decode instruction names as a source, then `stall` and `bubble` are 1 for exactly one cycle.
- R4: A store (class 2'b10) in execute with a load in decode gives exactly one stall cycle, whatever the register indices are.
- R5: A store in execute with a store in decode gives no stall.
- R6: Register index 0 never causes a load-use or floating-point-use stall, even when it matches.
- R7: When both source fields match the producer's destination, the result is still a single one-cycle stall and not two.
- R8: While `mispredict` is 1, `flush` is 1 and `stall`, `bubble` and `in_ready` are 0. The decode instruction and any offered input are discarded, and `ex_valid` is 0 in the next cycle.
- R9: After a mispredict cycle with `redirect_ready` at 1, `in_ready` is back at 1 in the next cycle (no extra penalty). With `redirect_ready` at 0, `in_ready` is 0 for exactly one refill cycle.
- R10: A stall holds the decode instruction, and `ex_valid` is 0 in the next cycle (the bubble). On the cycle after that, the held instruction appears in execute with its own tag on `ex_tag`. An instruction that is not stalled reaches execute two edges after it is accepted.
- R11: `in_ready` is 0 exactly when there is a stall, a mispredict or a refill cycle. A descriptor is taken only on an edge where both `in_valid` and `in_ready` are 1.
- R12: No other case stalls: integer-to-anything dependencies, loads whose hit flag is 0, and an empty stage all give `stall` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch offers a descriptor |
| in_ready | output | 1 | Block can take the offered descriptor this cycle |
| in_cls | input | 2 | Class: 00 integer/branch, 01 load, 10 store, 11 floating point |
| in_src_a | input | REG_W (5) | First source register index |
| in_src_b | input | REG_W (5) | Second source register index |
| in_dst | input | REG_W (5) | Destination register index |
| in_hit | input | 1 | Load hits the cache |
| in_tag | input | TAG_W (8) | Trace tag carried to execute |
| mispredict | input | 1 | Branch in execute resolved as mispredicted |
| redirect_ready | input | 1 | Corrected path is available at once |
| stall | output | 1 | Fetch and decode hold this cycle |
| bubble | output | 1 | A NOP goes into execute on the next edge |
| flush | output | 1 | Younger instruction is being discarded |
| ex_valid | output | 1 | Execute stage holds a real instruction |
| ex_tag | output | TAG_W (8) | Tag of the instruction in execute |

## Verification
`stall`, `bubble`, `flush` and `in_ready` are combinational. They are due in the same cycle as the stage contents and the `mispredict` input that cause them. `ex_valid` and `ex_tag` change one edge after a decode-to-execute move, so an accepted descriptor shows on them two edges after acceptance. The refill penalty shows on `in_ready` one edge after the mispredict cycle. The bench drives inputs just after the falling edge and compares all six outputs 2 ns later against a behavioural model of the stage contents, which it then advances to the next edge.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  parameter int REG_W = 5;
  parameter int TAG_W = 8;
  parameter int NSRC  = 2;

  typedef enum logic [1:0] {
    CLS_INT   = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10,
    CLS_FP    = 2'b11
  } op_class_e;

  typedef struct packed {
    logic                        valid;
    op_class_e                   cls;
    logic [NSRC-1:0][REG_W-1:0]  src;
    logic [REG_W-1:0]            dst;
    logic                        hit;
    logic [TAG_W-1:0]            tag;
  } uop_t;
endpackage

// File: rtl/ilk_uop_reg.sv
module ilk_uop_reg
  import ilk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic hold,
  input  uop_t d,
  output uop_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (kill)   q <= '0;
    else if (!hold)  q <= d;
  end

  // R10: a held stage keeps its descriptor
  assert_hold_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !kill) |=> $stable(q));

  // R8: a killed stage is empty afterwards
  assert_kill_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !q.valid);
endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       d_valid,
  input  op_class_e                  d_cls,
  input  logic [NSRC-1:0][REG_W-1:0] d_src,
  input  logic                       e_valid,
  input  op_class_e                  e_cls,
  input  logic [REG_W-1:0]           e_dst,
  input  logic                       e_hit,
  output logic                       hazard
);
  logic [NSRC-1:0] src_match;
  logic            pair, dst_nz, any_match;
  logic            load_use, fp_use, store_load;

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign src_match[i] = (d_src[i] == e_dst);
  end

  always_comb begin
    pair       = d_valid && e_valid;
    dst_nz     = (e_dst != '0);
    any_match  = |src_match;
    load_use   = pair && (e_cls == CLS_LOAD) && e_hit && dst_nz && any_match;
    fp_use     = pair && (e_cls == CLS_FP) && dst_nz && any_match;
    store_load = pair && (e_cls == CLS_STORE) && (d_cls == CLS_LOAD);
    hazard     = load_use || fp_use || store_load;
  end

  // R5: store after store never interlocks
  assert_store_store_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (e_cls == CLS_STORE && d_cls == CLS_STORE) |-> !hazard);

  // R6: producer writing register 0 never interlocks
  assert_zero_reg_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (e_dst == '0 && e_cls != CLS_STORE) |-> !hazard);

  // R12: integer producers are always bypassed
  assert_int_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (e_cls == CLS_INT) |-> !hazard);
endmodule

// File: rtl/ilk_redirect.sv
module ilk_redirect (
  input  logic clk,
  input  logic rst_n,
  input  logic mispredict,
  input  logic redirect_ready,
  output logic refill
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refill <= 1'b0;
    else        refill <= mispredict && !redirect_ready;
  end

  // R9: late redirect costs one refill cycle
  assert_late_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mispredict && !redirect_ready) |=> refill);

  // R9: ready redirect costs nothing extra
  assert_ready_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mispredict && redirect_ready) |=> !refill);
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import ilk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_cls,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  input  logic [REG_W-1:0] in_dst,
  input  logic             in_hit,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             mispredict,
  input  logic             redirect_ready,
  output logic             stall,
  output logic             bubble,
  output logic             flush,
  output logic             ex_valid,
  output logic [TAG_W-1:0] ex_tag
);
  uop_t dec_q, ex_q, dec_d;
  logic hazard, refill, fire;

  ilk_hazard u_hazard (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (dec_q.valid),
    .d_cls   (dec_q.cls),
    .d_src   (dec_q.src),
    .e_valid (ex_q.valid),
    .e_cls   (ex_q.cls),
    .e_dst   (ex_q.dst),
    .e_hit   (ex_q.hit),
    .hazard  (hazard)
  );

  ilk_redirect u_redirect (
    .clk            (clk),
    .rst_n          (rst_n),
    .mispredict     (mispredict),
    .redirect_ready (redirect_ready),
    .refill         (refill)
  );

  always_comb begin
    stall    = hazard && !mispredict;
    bubble   = hazard && !mispredict;
    flush    = mispredict;
    in_ready = !hazard && !mispredict && !refill;
    fire     = in_valid && in_ready;
    dec_d    = '0;
    if (fire) begin
      dec_d.valid  = 1'b1;
      dec_d.cls    = op_class_e'(in_cls);
      dec_d.src[0] = in_src_a;
      dec_d.src[1] = in_src_b;
      dec_d.dst    = in_dst;
      dec_d.hit    = in_hit;
      dec_d.tag    = in_tag;
    end
  end

  ilk_uop_reg u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .kill  (mispredict),
    .hold  (hazard),
    .d     (dec_d),
    .q     (dec_q)
  );

  ilk_uop_reg u_ex (
    .clk   (clk),
    .rst_n (rst_n),
    .kill  (mispredict || hazard),
    .hold  (1'b0),
    .d     (dec_q),
    .q     (ex_q)
  );

  assign ex_valid = ex_q.valid;
  assign ex_tag   = ex_q.tag;

  // R7: every stall lasts a single cycle
  assert_single_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R11: no transfer while stalled
  assert_ready_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !in_ready);

  // R10: a stall sends a bubble into execute
  assert_bubble_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_valid);

  // R8: flush leaves execute empty
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ex_valid);
endmodule

// File: tb/pipe_interlock_tb.sv
`timescale 1ns/1ps
module pipe_interlock_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, in_hit = 0, mispredict = 0, redirect_ready = 1;
  logic [1:0] in_cls = 0;
  logic [4:0] in_src_a = 0, in_src_b = 0, in_dst = 0;
  logic [7:0] in_tag = 0;
  logic stall, bubble, flush, ex_valid;
  logic [7:0] ex_tag;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  bit md_v, me_v, m_pen;
  int md_cls, md_a, md_b, md_dst, md_hit, md_tag;
  int me_cls, me_dst, me_hit, me_tag;
  bit last_fire;

  always #4 clk = ~clk;

  pipe_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .in_hit(in_hit), .in_tag(in_tag), .mispredict(mispredict),
    .redirect_ready(redirect_ready), .stall(stall), .bubble(bubble),
    .flush(flush), .ex_valid(ex_valid), .ex_tag(ex_tag)
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  // compare at negedge+2, then advance model to next edge
  task automatic step();
    bit ld, fp, sl, hz, both, rdy;
    string req;
    #2;
    both = (md_a == me_dst) && (md_b == me_dst);
    ld = md_v && me_v && me_cls == 1 && me_hit != 0 && me_dst != 0 &&
         (md_a == me_dst || md_b == me_dst);
    fp = md_v && me_v && me_cls == 3 && me_dst != 0 &&
         (md_a == me_dst || md_b == me_dst);
    sl = md_v && me_v && me_cls == 2 && md_cls == 1;
    hz = ld || fp || sl;
    rdy = !hz && !mispredict && !m_pen;
    if (mispredict) req = "R8";
    else if (m_pen) req = "R9";
    else if ((ld || fp) && both) req = "R7";
    else if (ld) req = "R2";
    else if (fp) req = "R3";
    else if (sl) req = "R4";
    else if (md_v && me_v && me_cls == 2 && md_cls == 2) req = "R5";
    else if (md_v && me_v && me_dst == 0 && (me_cls == 1 || me_cls == 3)) req = "R6";
    else req = "R12";
    chk(req, "stall", stall, hz && !mispredict);
    chk(req, "bubble", bubble, hz && !mispredict);
    chk(req, "flush", flush, mispredict);
    chk((req == "R12") ? "R11" : req, "in_ready", in_ready, rdy);
    chk("R10", "ex_valid", ex_valid, me_v);
    if (me_v) chk("R10", "ex_tag", ex_tag, me_tag);
    last_fire = in_valid && rdy;
    if (mispredict) begin
      md_v = 0; me_v = 0;
    end else if (hz) begin
      me_v = 0;
    end else begin
      me_v = md_v; me_cls = md_cls; me_dst = md_dst; me_hit = md_hit; me_tag = md_tag;
      md_v = last_fire; md_cls = in_cls; md_a = in_src_a; md_b = in_src_b;
      md_dst = in_dst; md_hit = in_hit; md_tag = in_tag;
    end
    m_pen = mispredict && !redirect_ready;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 0; mispredict = 0;
    repeat (n) step();
  endtask

  // offer one descriptor until it is taken
  task automatic offer(int cls, int a, int b, int d, int hit, int tag);
    in_valid = 1; in_cls = 2'(cls); in_src_a = 5'(a); in_src_b = 5'(b);
    in_dst = 5'(d); in_hit = 1'(hit); in_tag = 8'(tag); mispredict = 0;
    do step(); while (!last_fire);
    in_valid = 0;
  endtask

  task automatic mis(bit rr);
    mispredict = 1; redirect_ready = rr;
    step();
    mispredict = 0; redirect_ready = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "stall", stall, 0);
    chk("R1", "ex_valid", ex_valid, 0);
    chk("R1", "in_ready", in_ready, 1);
    rst_n = 1;
    idle(1);
    // R12: integer dependency, no stall
    offer(0, 1, 2, 3, 0, 10); offer(0, 3, 3, 4, 0, 11); idle(3);
    // R2: load-hit use
    offer(1, 1, 0, 5, 1, 20); offer(0, 5, 2, 6, 0, 21); idle(3);
    // R12: load miss use, no interlock
    offer(1, 1, 0, 6, 0, 22); offer(0, 6, 0, 7, 0, 23); idle(3);
    // R6: register 0
    offer(1, 1, 0, 0, 1, 24); offer(0, 0, 0, 7, 0, 25); idle(3);
    // R3: fp use
    offer(3, 1, 2, 7, 0, 30); offer(3, 2, 7, 8, 0, 31); idle(3);
    // R7: both sources match
    offer(1, 1, 0, 9, 1, 32); offer(0, 9, 9, 10, 0, 33); idle(3);
    // R4 / R5: store-load and store-store
    offer(2, 1, 2, 0, 0, 40); offer(1, 3, 0, 4, 1, 41); idle(3);
    offer(2, 1, 2, 0, 0, 42); offer(2, 3, 4, 0, 0, 43); idle(3);
    // R8: mispredict overriding a pending load-use stall, ready redirect
    offer(1, 1, 0, 5, 1, 50); offer(0, 5, 0, 6, 0, 51);
    in_valid = 1; in_tag = 52; mis(1);
    offer(0, 1, 1, 2, 0, 53); idle(3);
    // R9: late redirect costs one refill cycle
    offer(0, 1, 1, 2, 0, 60);
    in_valid = 1; in_tag = 61; mis(0);
    offer(0, 1, 1, 2, 0, 62); idle(3);
    // mixed stream
    for (int i = 0; i < 3000; i++) begin
      in_valid = 1'($urandom_range(0, 3) != 0);
      in_cls = 2'($urandom_range(0, 3));
      in_src_a = 5'($urandom_range(0, 3));
      in_src_b = 5'($urandom_range(0, 3));
      in_dst = 5'($urandom_range(0, 3));
      in_hit = 1'($urandom_range(0, 1));
      in_tag = 8'(i);
      mispredict = ($urandom_range(0, 15) == 0);
      redirect_ready = 1'($urandom_range(0, 1));
      step();
    end
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule